// File: doc/BRIEF.md
# Capability Load/Store Unit

This unit moves capabilities between a capability segment in memory and a bank of eight wide capability registers. A capability in memory is one 24-bit word that holds a 16-bit index into a system table and an 8-bit rights mask. Inside the bank, a capability is 48 bits wide and holds the segment base, the segment limit and the rights. To load a capability, the unit reads the compact word through a segment register that allows reading capabilities. It then fetches the three-word table entry at `tbl_base + 3*index` and checks the entry's lock flag and checksum. After that it writes the wide image into the destination register and records the index in that register's save slot.

To store a capability, the unit rebuilds the compact word from the saved index and the current rights of the source register. It writes the word into a segment that grants the write-capability right. All memory traffic goes through a single word-wide request/ready port. A preset port loads a register image and a save slot directly, so that the root segment registers can be set up. An operation ends with exactly one of three one-cycle pulses: done, fault (with a code) or trap.

Top module: `cap_ldst_unit`

## Requirements
- R1: After reset, every register image and every save slot reads zero, `mem_req` is low and none of `done`, `fault` or `trap` is asserted.
- R2: A successful load writes `{w0[23:0], w1[15:0], rights}` into the destination register, where w0 and w1 are entry words 0 and 1 and rights is bits [23:16] of the stored word. The register is readable on `rd_cap` once `done` has pulsed.
- R3: A load reads the stored word at `seg_base + op_off`, where seg_base is bits [47:24] of the segment register. It then reads entry words 0, 1 and 2 at `tbl_base + 3*idx + 0/1/2`, in that order, where idx is bits [15:0] of the stored word. A successful load makes exactly four memory accesses.
- R4: A successful load places idx in the destination register's save slot, which is readable on `rd_idx`.
- R5: A store writes one word, `{rights[7:0] of source register, saved slot of source register}`, at `seg_base + op_off` with `mem_we` high. It then pulses `done`.
- R6: A load whose segment register lacks the read-capability right (rights bit 5) pulses `fault` with code 1. It makes no memory access and leaves the destination unchanged.
- R7: A store whose segment register lacks the write-capability right (rights bit 4) pulses `fault` with code 1 and makes no memory access.
- R8: An offset that is not below the segment limit (register bits [23:8]) pulses `fault` with code 2 and makes no memory access. The rights check takes precedence over this check.
- R9: If bit 23 of entry word 1 (the lock flag) is set, the load pulses `trap` and updates neither the register nor its slot. The lock check takes precedence over the checksum check.
- R10: If entry word 2 differs from the XOR of words 0 and 1, the load pulses `fault` with code 3 and leaves the register and its slot unchanged.
- R11: Each accepted operation produces exactly one one-cycle pulse on exactly one of `done`, `fault` or `trap`. A memory request keeps its address, data and direction stable until `mem_ready`.
- R12: A preset write takes effect only while `busy` is low. It sets the selected register image and slot, and a preset issued during an operation is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Start an operation (sampled while idle) |
| op_store | input | 1 | 0 = load capability, 1 = store capability |
| op_dst | input | 3 | Load destination / store source register |
| op_seg | input | 3 | Register addressing the capability segment |
| op_off | input | 16 | Word offset within the segment |
| tbl_base | input | 24 | System table base address |
| pre_we | input | 1 | Preset write strobe |
| pre_sel | input | 3 | Preset register select |
| pre_cap | input | 48 | Preset register image |
| pre_idx | input | 16 | Preset save-slot value |
| rd_sel | input | 3 | Readback register select |
| rd_cap | output | 48 | Readback register image |
| rd_idx | output | 16 | Readback save slot |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 24 | Memory word address |
| mem_wdata | output | 24 | Memory write data |
| mem_rdata | input | 24 | Memory read data, valid with ready |
| mem_ready | input | 1 | Memory completes the request this cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation completed |
| fault | output | 1 | Operation rejected |
| trap | output | 1 | Load hit a locked table entry |
| fault_code | output | 2 | 1 rights, 2 bounds, 3 checksum; valid with fault |

## Verification
Some properties are checked by assertions on every cycle. These cover: the three end pulses are mutually exclusive and last one cycle; a stalled request holds its address, data and direction; a rejected operation never reaches memory; a register is never written by a load and a preset in the same cycle. Other behaviour can only be shown by the bench scenarios. These are the exact register image and save slot after a load, the address sequence through the table, the word a store rebuilds, the precedence of lock over checksum and of rights over bounds, and a preset being ignored while busy. The bench sweeps every destination register against many table entries and memory latencies.

// File: rtl/cap_pkg.sv
package cap_pkg;
   localparam int RIGHT_WRCAP = 4;
   localparam int RIGHT_RDCAP = 5;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CAPRD,
      ST_ENT0,
      ST_ENT1,
      ST_ENT2,
      ST_STWR
   } lsu_state_t;

   typedef enum logic [1:0] {
      FC_NONE   = 2'd0,
      FC_RIGHTS = 2'd1,
      FC_BOUNDS = 2'd2,
      FC_CHKSUM = 2'd3
   } fault_code_t;
endpackage

// File: rtl/cap_regfile.sv
module cap_regfile #(
   parameter int NREG = 8,
   parameter int CW   = 48,
   parameter int IW   = 16,
   localparam int SW  = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pre_we,
   input  logic [SW-1:0] pre_sel,
   input  logic [CW-1:0] pre_cap,
   input  logic [IW-1:0] pre_idx,
   input  logic          ld_we,
   input  logic [SW-1:0] ld_sel,
   input  logic [CW-1:0] ld_cap,
   input  logic [IW-1:0] ld_idx,
   input  logic [SW-1:0] a_sel,
   output logic [CW-1:0] a_cap,
   input  logic [SW-1:0] b_sel,
   output logic [CW-1:0] b_cap,
   output logic [IW-1:0] b_idx,
   input  logic [SW-1:0] c_sel,
   output logic [CW-1:0] c_cap,
   output logic [IW-1:0] c_idx
);
   logic [CW-1:0] cap_q [NREG];
   logic [IW-1:0] idx_q [NREG];

   generate
      if (NREG < 2) begin : g_bad_nreg
         $error("cap_regfile: NREG must be at least 2");
      end
      for (genvar g = 0; g < NREG; g++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cap_q[g] <= '0;
               idx_q[g] <= '0;
            end else if (ld_we && ld_sel == SW'(g)) begin
               cap_q[g] <= ld_cap;
               idx_q[g] <= ld_idx;
            end else if (pre_we && pre_sel == SW'(g)) begin
               cap_q[g] <= pre_cap;
               idx_q[g] <= pre_idx;
            end
         end
      end
   endgenerate

   assign a_cap = cap_q[a_sel];
   assign b_cap = cap_q[b_sel];
   assign b_idx = idx_q[b_sel];
   assign c_cap = cap_q[c_sel];
   assign c_idx = idx_q[c_sel];

   // R12: presets are gated by idle, loads commit only while busy
   assert_ld_pre_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(ld_we && pre_we));
endmodule

// File: rtl/cap_gate.sv
module cap_gate #(
   parameter int AW           = 24,
   parameter int LW           = 16,
   parameter int RW           = 8,
   parameter bit BOUNDS_CHECK = 1'b1,
   localparam int CW          = AW + LW + RW
) (
   input  logic [CW-1:0] seg_cap,
   input  logic          is_store,
   input  logic [LW-1:0] off,
   output logic          ok,
   output logic [1:0]    code,
   output logic [AW-1:0] addr
);
   import cap_pkg::*;

   logic [RW-1:0] rights;
   logic [LW-1:0] limit;
   logic [AW-1:0] base;
   logic          rights_ok;
   logic          in_bounds;

   assign rights = seg_cap[RW-1:0];
   assign limit  = seg_cap[RW+LW-1:RW];
   assign base   = seg_cap[CW-1:RW+LW];

   generate
      if (RIGHT_RDCAP >= RW || RIGHT_WRCAP >= RW) begin : g_bad_rw
         $error("cap_gate: rights field too narrow");
      end
      if (BOUNDS_CHECK) begin : g_bounds
         assign in_bounds = off < limit;
      end else begin : g_nobounds
         assign in_bounds = 1'b1;
      end
   endgenerate

   assign rights_ok = is_store ? rights[RIGHT_WRCAP] : rights[RIGHT_RDCAP];
   assign ok        = rights_ok && in_bounds;
   assign addr      = base + AW'(off);

   always_comb begin
      if (!rights_ok)      code = FC_RIGHTS;
      else if (!in_bounds) code = FC_BOUNDS;
      else                 code = FC_NONE;
   end
endmodule

// File: rtl/cap_seq.sv
module cap_seq #(
   parameter int AW   = 24,
   parameter int DW   = 24,
   parameter int LW   = 16,
   parameter int RW   = 8,
   parameter int IW   = 16,
   parameter int NREG = 8,
   parameter int LOCK_BIT = 23,
   localparam int SW  = $clog2(NREG),
   localparam int CW  = AW + LW + RW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          op_valid,
   input  logic          op_store,
   input  logic [SW-1:0] op_dst,
   input  logic          gate_ok,
   input  logic [1:0]    gate_code,
   input  logic [AW-1:0] gate_addr,
   input  logic [RW-1:0] src_rights,
   input  logic [IW-1:0] src_idx,
   input  logic [AW-1:0] tbl_base,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   input  logic          mem_ready,
   output logic          ld_we,
   output logic [SW-1:0] ld_sel,
   output logic [CW-1:0] ld_cap,
   output logic [IW-1:0] ld_idx,
   output logic          busy,
   output logic          done,
   output logic          fault,
   output logic          trap,
   output logic [1:0]    fault_code
);
   import cap_pkg::*;

   lsu_state_t    st_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] wd_q;
   logic [DW-1:0] w0_q, w1_q;
   logic [RW-1:0] rights_q;
   logic [IW-1:0] idx_q;
   logic [SW-1:0] dst_q;
   logic          done_q, fault_q, trap_q;
   logic [1:0]    code_q;
   logic [AW-1:0] ent_addr;
   logic          locked, sum_bad;

   generate
      if (RW + IW != DW) begin : g_bad_fmt
         $error("cap_seq: rights plus index must fill one word");
      end
      if (AW < DW || LOCK_BIT >= DW || LOCK_BIT < LW) begin : g_bad_lock
         $error("cap_seq: lock bit or address width out of range");
      end
   endgenerate

   assign ent_addr = tbl_base + AW'({mem_rdata[IW-1:0], 1'b0}) + AW'(mem_rdata[IW-1:0]);
   assign locked   = w1_q[LOCK_BIT];
   assign sum_bad  = (w0_q ^ w1_q) != mem_rdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         addr_q   <= '0;
         wd_q     <= '0;
         w0_q     <= '0;
         w1_q     <= '0;
         rights_q <= '0;
         idx_q    <= '0;
         dst_q    <= '0;
         done_q   <= 1'b0;
         fault_q  <= 1'b0;
         trap_q   <= 1'b0;
         code_q   <= FC_NONE;
      end else begin
         done_q  <= 1'b0;
         fault_q <= 1'b0;
         trap_q  <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (op_valid) begin
                  dst_q <= op_dst;
                  if (!gate_ok) begin
                     fault_q <= 1'b1;
                     code_q  <= gate_code;
                  end else begin
                     addr_q <= gate_addr;
                     if (op_store) begin
                        wd_q <= {src_rights, src_idx};
                        st_q <= ST_STWR;
                     end else begin
                        st_q <= ST_CAPRD;
                     end
                  end
               end
            end
            ST_CAPRD: if (mem_ready) begin
               rights_q <= mem_rdata[DW-1:IW];
               idx_q    <= mem_rdata[IW-1:0];
               addr_q   <= ent_addr;
               st_q     <= ST_ENT0;
            end
            ST_ENT0: if (mem_ready) begin
               w0_q   <= mem_rdata;
               addr_q <= addr_q + AW'(1);
               st_q   <= ST_ENT1;
            end
            ST_ENT1: if (mem_ready) begin
               w1_q   <= mem_rdata;
               addr_q <= addr_q + AW'(1);
               st_q   <= ST_ENT2;
            end
            ST_ENT2: if (mem_ready) begin
               st_q <= ST_IDLE;
               if (locked) begin
                  trap_q <= 1'b1;
               end else if (sum_bad) begin
                  fault_q <= 1'b1;
                  code_q  <= FC_CHKSUM;
               end else begin
                  done_q <= 1'b1;
               end
            end
            ST_STWR: if (mem_ready) begin
               st_q   <= ST_IDLE;
               done_q <= 1'b1;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign ld_we  = (st_q == ST_ENT2) && mem_ready && !locked && !sum_bad;
   assign ld_sel = dst_q;
   assign ld_cap = {w0_q[AW-1:0], w1_q[LW-1:0], rights_q};
   assign ld_idx = idx_q;

   assign mem_req    = (st_q != ST_IDLE);
   assign mem_we     = (st_q == ST_STWR);
   assign mem_addr   = addr_q;
   assign mem_wdata  = wd_q;
   assign busy       = (st_q != ST_IDLE);
   assign done       = done_q;
   assign fault      = fault_q;
   assign trap       = trap_q;
   assign fault_code = code_q;

   // R11: one ending pulse at a time, each lasting a single cycle
   assert_resp_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, fault, trap}));
   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_trap_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      trap |=> !trap);
   // R11: a stalled request holds its attributes
   assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));
   // R6: an operation rejected by the gate never reaches memory
   assert_reject_no_mem_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && op_valid && !gate_ok) |=> (!mem_req && fault));
   // R9: a locked entry never commits a register write
   assert_lock_no_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ld_we |=> (done && !trap));
endmodule

// File: rtl/cap_ldst_unit.sv
module cap_ldst_unit #(
   parameter int AW           = 24,
   parameter int DW           = 24,
   parameter int LW           = 16,
   parameter int RW           = 8,
   parameter int IW           = 16,
   parameter int NREG         = 8,
   parameter bit BOUNDS_CHECK = 1'b1,
   localparam int SW          = $clog2(NREG),
   localparam int CW          = AW + LW + RW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          op_valid,
   input  logic          op_store,
   input  logic [SW-1:0] op_dst,
   input  logic [SW-1:0] op_seg,
   input  logic [LW-1:0] op_off,
   input  logic [AW-1:0] tbl_base,
   input  logic          pre_we,
   input  logic [SW-1:0] pre_sel,
   input  logic [CW-1:0] pre_cap,
   input  logic [IW-1:0] pre_idx,
   input  logic [SW-1:0] rd_sel,
   output logic [CW-1:0] rd_cap,
   output logic [IW-1:0] rd_idx,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   input  logic          mem_ready,
   output logic          busy,
   output logic          done,
   output logic          fault,
   output logic          trap,
   output logic [1:0]    fault_code
);
   logic          ld_we;
   logic [SW-1:0] ld_sel;
   logic [CW-1:0] ld_cap;
   logic [IW-1:0] ld_idx;
   logic [CW-1:0] seg_cap;
   logic [CW-1:0] src_cap;
   logic [IW-1:0] src_idx;
   logic          gate_ok;
   logic [1:0]    gate_code;
   logic [AW-1:0] gate_addr;
   logic          pre_ok;

   assign pre_ok = pre_we && !busy;

   cap_regfile #(.NREG(NREG), .CW(CW), .IW(IW)) u_rf (
      .clk(clk), .rst_n(rst_n),
      .pre_we(pre_ok), .pre_sel(pre_sel), .pre_cap(pre_cap), .pre_idx(pre_idx),
      .ld_we(ld_we), .ld_sel(ld_sel), .ld_cap(ld_cap), .ld_idx(ld_idx),
      .a_sel(op_seg), .a_cap(seg_cap),
      .b_sel(op_dst), .b_cap(src_cap), .b_idx(src_idx),
      .c_sel(rd_sel), .c_cap(rd_cap), .c_idx(rd_idx)
   );

   cap_gate #(.AW(AW), .LW(LW), .RW(RW), .BOUNDS_CHECK(BOUNDS_CHECK)) u_gate (
      .seg_cap(seg_cap), .is_store(op_store), .off(op_off),
      .ok(gate_ok), .code(gate_code), .addr(gate_addr)
   );

   cap_seq #(.AW(AW), .DW(DW), .LW(LW), .RW(RW), .IW(IW), .NREG(NREG)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .op_valid(op_valid), .op_store(op_store), .op_dst(op_dst),
      .gate_ok(gate_ok), .gate_code(gate_code), .gate_addr(gate_addr),
      .src_rights(src_cap[RW-1:0]), .src_idx(src_idx), .tbl_base(tbl_base),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
      .ld_we(ld_we), .ld_sel(ld_sel), .ld_cap(ld_cap), .ld_idx(ld_idx),
      .busy(busy), .done(done), .fault(fault), .trap(trap), .fault_code(fault_code)
   );

   // R12: a preset presented during an operation leaves memory traffic untouched
   assert_pre_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && pre_we && mem_req && !mem_ready) |=> $stable(mem_addr));
endmodule

// File: tb/cap_ldst_unit_tb.sv
module cap_ldst_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0, op_store = 1'b0;
   logic [2:0]  op_dst = '0, op_seg = '0;
   logic [15:0] op_off = '0;
   logic [23:0] tbl_base = 24'h000100;
   logic        pre_we = 1'b0;
   logic [2:0]  pre_sel = '0;
   logic [47:0] pre_cap = '0;
   logic [15:0] pre_idx = '0;
   logic [2:0]  rd_sel = '0;
   logic [47:0] rd_cap;
   logic [15:0] rd_idx;
   logic        mem_req, mem_we, mem_ready;
   logic [23:0] mem_addr, mem_wdata, mem_rdata;
   logic        busy, done, fault, trap;
   logic [1:0]  fault_code;

   always #5 clk = ~clk;

   cap_ldst_unit u_dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_store(op_store),
      .op_dst(op_dst), .op_seg(op_seg), .op_off(op_off), .tbl_base(tbl_base),
      .pre_we(pre_we), .pre_sel(pre_sel), .pre_cap(pre_cap), .pre_idx(pre_idx),
      .rd_sel(rd_sel), .rd_cap(rd_cap), .rd_idx(rd_idx),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ready(mem_ready),
      .busy(busy), .done(done), .fault(fault), .trap(trap), .fault_code(fault_code)
   );

   // memory model with programmable wait states
   logic [23:0] mem [0:1023];
   int          lat = 0;
   int          wait_cnt = 0;
   int          acc_total = 0;
   logic [23:0] addr_log [0:4095];
   logic        we_log [0:4095];

   assign mem_ready = mem_req && (wait_cnt >= lat);
   assign mem_rdata = mem[mem_addr[9:0]];

   always @(posedge clk) begin
      if (mem_req && !mem_ready) wait_cnt <= wait_cnt + 1;
      else wait_cnt <= 0;
      if (mem_req && mem_ready) begin
         addr_log[acc_total[11:0]] <= mem_addr;
         we_log[acc_total[11:0]]   <= mem_we;
         acc_total <= acc_total + 1;
         if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
      end
   end

   int n_chk = 0, n_bad = 0;
   logic [47:0] exp_cap [8];
   logic [15:0] exp_idx [8];

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [23:0] ent_w0(input int k);
      return 24'(24'h001000 + k * 24'h000111);
   endfunction
   function automatic logic [15:0] ent_lim(input int k);
      return 16'(k * 7 + 5);
   endfunction
   function automatic logic [7:0] seg_rights(input int j);
      return 8'(j * 29 + 3);
   endfunction

   task automatic read_reg(input int r, output logic [47:0] c, output logic [15:0] x);
      @(negedge clk);
      rd_sel = 3'(r);
      #1;
      c = rd_cap;
      x = rd_idx;
   endtask

   task automatic preset(input int r, input logic [47:0] c, input logic [15:0] x);
      @(negedge clk);
      pre_we = 1'b1; pre_sel = 3'(r); pre_cap = c; pre_idx = x;
      @(negedge clk);
      pre_we = 1'b0;
      exp_cap[r] = c;
      exp_idx[r] = x;
   endtask

   // kind: 1 done, 2 fault, 3 trap, 0 none
   task automatic run_op(input bit st, input int dst, input int seg, input int off,
                         input int l, input bit mid_pre, output int kind,
                         output logic [1:0] code, output int acc, output int first);
      int start, pulses, ncyc;
      bit seen;
      lat = l;
      start = acc_total;
      first = acc_total;
      pulses = 0; ncyc = 0; seen = 1'b0; kind = 0; code = '0;
      @(negedge clk);
      op_valid = 1'b1; op_store = st; op_dst = 3'(dst); op_seg = 3'(seg);
      op_off = 16'(off);
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         op_valid = 1'b0;
         if (mid_pre) begin
            pre_we = (i == 1); pre_sel = 3'd6; pre_cap = 48'hABCDEF_1234_55;
            pre_idx = 16'h7777;
         end
         pulses += int'(done) + int'(fault) + int'(trap);
         if (!seen && (done || fault || trap)) begin
            seen = 1'b1;
            kind = done ? 1 : (fault ? 2 : 3);
            code = fault_code;
            ncyc = i;
         end
         if (seen && i > ncyc) break;
      end
      pre_we = 1'b0;
      acc = acc_total - start;
      chk(pulses == 1, "R11 one pulse", 64'(pulses), 64'd1);
      chk(!busy, "R11 idle after", 64'(busy), 64'd0);
   endtask

   initial begin
      int cyc = 0;
      while (cyc < 150000) begin
         @(posedge clk);
         cyc++;
      end
      n_bad++;
      n_chk++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [47:0] c;
      logic [15:0] x;
      int kind, acc, first;
      logic [1:0] code;
      for (int a = 0; a < 1024; a++) mem[a] = 24'h0;
      // table at 0x100, entries 0..39
      for (int k = 0; k < 40; k++) begin
         mem[256 + 3*k]     = ent_w0(k);
         mem[256 + 3*k + 1] = {8'h00, ent_lim(k)};
         mem[256 + 3*k + 2] = ent_w0(k) ^ {8'h00, ent_lim(k)};
      end
      mem[256 + 3*7 + 1] = {8'h80, ent_lim(7)};
      mem[256 + 3*7 + 2] = ent_w0(7) ^ {8'h80, ent_lim(7)} ^ 24'h000001; // lock and bad sum
      mem[256 + 3*9 + 2] = mem[256 + 3*9 + 2] ^ 24'h000400;
      // capability segment at 0x20, 16 words
      for (int j = 0; j < 14; j++) mem[32 + j] = {seg_rights(j), 16'(j + 10)};
      mem[32 + 14] = {8'h3C, 16'd7};
      mem[32 + 15] = {8'h3C, 16'd9};
      for (int r = 0; r < 8; r++) begin exp_cap[r] = '0; exp_idx[r] = '0; end

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk(!mem_req && !done && !fault && !trap, "R1 outputs idle",
          64'({mem_req, done, fault, trap}), 64'd0);
      for (int r = 0; r < 8; r++) begin
         read_reg(r, c, x);
         chk(c == 48'h0 && x == 16'h0, "R1 reg zero", 64'({c, x}), 64'd0);
      end

      // R12 preset root segment register
      preset(0, {24'h000020, 16'd16, 8'h3F}, 16'h0000);
      read_reg(0, c, x);
      chk(c == exp_cap[0], "R12 preset image", 64'(c), 64'(exp_cap[0]));

      // R2 R3 R4 sweep: every destination, every in-range word, varying latency
      for (int d = 1; d < 8; d++) begin
         for (int j = 0; j < 14; j++) begin
            run_op(1'b0, d, 0, j, (d + j) % 3, 1'b0, kind, code, acc, first);
            exp_cap[d] = {ent_w0(j + 10), ent_lim(j + 10), seg_rights(j)};
            exp_idx[d] = 16'(j + 10);
            chk(kind == 1, "R2 load done", 64'(kind), 64'd1);
            chk(acc == 4, "R3 four accesses", 64'(acc), 64'd4);
            chk(addr_log[first[11:0]] == 24'(32 + j), "R3 cap word addr",
                64'(addr_log[first[11:0]]), 64'(32 + j));
            chk(addr_log[(first + 3) % 4096] == 24'(256 + 3*(j + 10) + 2), "R3 entry addr",
                64'(addr_log[(first + 3) % 4096]), 64'(256 + 3*(j + 10) + 2));
            read_reg(d, c, x);
            chk(c == exp_cap[d], "R2 image", 64'(c), 64'(exp_cap[d]));
            chk(x == exp_idx[d], "R4 slot", 64'(x), 64'(exp_idx[d]));
         end
      end

      // R9 locked entry (checksum also wrong: lock wins)
      run_op(1'b0, 3, 0, 14, 1, 1'b0, kind, code, acc, first);
      chk(kind == 3, "R9 trap", 64'(kind), 64'd3);
      read_reg(3, c, x);
      chk(c == exp_cap[3] && x == exp_idx[3], "R9 no update", 64'(c), 64'(exp_cap[3]));

      // R10 bad checksum
      run_op(1'b0, 4, 0, 15, 2, 1'b0, kind, code, acc, first);
      chk(kind == 2 && code == 2'd3, "R10 checksum fault", 64'({kind[3:0], code}), 64'h0B);
      read_reg(4, c, x);
      chk(c == exp_cap[4] && x == exp_idx[4], "R10 no update", 64'(c), 64'(exp_cap[4]));

      // R8 bounds: offset equal to limit
      run_op(1'b0, 4, 0, 16, 0, 1'b0, kind, code, acc, first);
      chk(kind == 2 && code == 2'd2, "R8 bounds fault", 64'({kind[3:0], code}), 64'h0A);
      chk(acc == 0, "R8 no access", 64'(acc), 64'd0);

      // R6 missing read-capability right (also out of bounds: rights wins)
      preset(2, {24'h000040, 16'd8, 8'h10}, 16'h0002);
      run_op(1'b0, 1, 2, 9, 0, 1'b0, kind, code, acc, first);
      chk(kind == 2 && code == 2'd1, "R6 rights fault", 64'({kind[3:0], code}), 64'h09);
      chk(acc == 0, "R6 no access", 64'(acc), 64'd0);
      read_reg(1, c, x);
      chk(c == exp_cap[1], "R6 dest unchanged", 64'(c), 64'(exp_cap[1]));

      // R7 store through segment lacking write-capability right
      preset(4, {24'h000060, 16'd8, 8'h20}, 16'h0004);
      run_op(1'b1, 1, 4, 1, 0, 1'b0, kind, code, acc, first);
      chk(kind == 2 && code == 2'd1, "R7 rights fault", 64'({kind[3:0], code}), 64'h09);
      chk(acc == 0, "R7 no access", 64'(acc), 64'd0);

      // R5 stores into a write-only segment
      preset(5, {24'h000060, 16'd8, 8'h10}, 16'h0005);
      for (int s = 0; s < 8; s++) begin
         run_op(1'b1, s, 5, s, s % 3, 1'b0, kind, code, acc, first);
         chk(kind == 1 && acc == 1, "R5 store done", 64'({kind, acc}), 64'h0000000100000001);
         chk(we_log[first[11:0]] == 1'b1, "R5 write strobe", 64'(we_log[first[11:0]]), 64'd1);
         chk(mem[96 + s] == {exp_cap[s][7:0], exp_idx[s]}, "R5 stored word",
             64'(mem[96 + s]), 64'({exp_cap[s][7:0], exp_idx[s]}));
      end

      // R12 preset ignored while busy
      run_op(1'b0, 1, 0, 0, 3, 1'b1, kind, code, acc, first);
      exp_cap[1] = {ent_w0(10), ent_lim(10), seg_rights(0)};
      exp_idx[1] = 16'd10;
      read_reg(6, c, x);
      chk(c == exp_cap[6] && x == exp_idx[6], "R12 busy preset ignored", 64'(c),
          64'(exp_cap[6]));
      read_reg(1, c, x);
      chk(c == exp_cap[1], "R2 image after preset attempt", 64'(c), 64'(exp_cap[1]));

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule